// File: doc/BRIEF.md
# SECDED-protected SRAM controller with partial-write merge

The controller sits between a bus master and a 64 KB on-chip memory organised as 72-bit locations: 64 data bits followed by 8 check bits. Each request carries a byte address, a size code (1, 2, 4 or 8 bytes) and, for writes, a full 64-bit data bus whose bytes are taken from their own lanes. Reads return the whole doubleword after checking and, where possible, correcting it. An 8-byte write is stored at once with freshly encoded check bits and never looks at the old contents. This is how software fills a memory whose check bits start out as garbage. A narrower write first reads and checks the old doubleword, merges the new bytes into it and stores the result with new check bits, all in the second cycle.

The memory is two 32 KB banks with separate selects. The lower bank holds contents across standby. While standby is asserted, or reset is active, the controller takes no requests and drives no bank select or write strobe. A partial write that is caught mid-flight by standby is dropped and answered with an error. Every detected error updates a small set of status outputs (address, syndrome, kind) and produces a one-cycle event pulse.

The control path has three states. HOLD is the reset state and the standby state. It goes to IDLE on the first clock with standby low. IDLE accepts a request when standby is low. A full write stays in IDLE, and every other request goes to CHECK. IDLE goes to HOLD when standby rises. CHECK decodes the returned word, responds, and for a partial write commits the merge. It returns to IDLE, or to HOLD if standby is high.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: An accepted 8-byte write (size code 3) drives the write strobe in its acceptance cycle with the request data in memory bits [71:8] and its check bits in [7:0]. It performs no memory read, and the response (rsp_valid=1, rsp_err=0) appears the cycle after acceptance.
- R2: The check bits use a Hsiao code. For each single-bit data word, the check byte has weight 3 or 5, and all 64 such check bytes are distinct. An all-zero data word encodes to an all-zero check byte.
- R3: A read responds on the second cycle after acceptance (rsp_valid low in the first). On an error-free word it returns the stored data with rsp_err=0 and no event pulse.
- R4: A single flipped data bit is corrected in rsp_rdata with rsp_err=0. A one-cycle err_corr_pulse is raised with the response, stat_kind becomes 1, stat_addr becomes the request address, and stat_syn equals that bit's check-byte column.
- R5: A single flipped check bit at memory bit j (0..7) returns the data unchanged with err_corr_pulse, and stat_syn equals 1<<j.
- R6: Two flipped bits give rsp_err=1, a one-cycle err_unc_pulse and stat_kind=2.
- R7: A stored 72-bit word of all zeros or all ones is reported like R6, even though its syndrome may be zero.
- R8: Byte offset k (0..7) maps to data bits [63-8k -: 8], so offset 0 holds the most significant byte. A 1, 2 or 4-byte write (size codes 0, 1, 2) replaces only the bytes of its naturally aligned group, ignoring address bits below its size. The new bytes come from their own lanes of req_wdata, the other bytes keep their old values, the check bits are recomputed, and the response appears the second cycle after acceptance.
- R9: When the old word of a partial write has a correctable error, the merge uses the corrected data and err_corr_pulse is raised.
- R10: When the old word of a partial write is uncorrectable, no write is made and the response carries rsp_err=1 with err_unc_pulse.
- R11: Address bit 15 = 0 selects bank mem_cs_lo and 1 selects mem_cs_hi. mem_idx is address bits [14:3], and at most one bank select is high.
- R12: While standby is high, req_ready is low and neither bank is selected. A partial write whose check cycle sees standby high is not written and responds with rsp_err=1. req_ready rises one cycle after standby falls.
- R13: During reset req_ready, rsp_valid, both pulses and stat_kind are 0, and req_ready first rises one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby request, blocks all memory activity |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0/1/2/3 = 1/2/4/8 bytes |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 64 | Write data, bytes in their own lanes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Uncorrectable or blocked |
| rsp_rdata | output | 64 | Corrected read data |
| mem_cs_lo | output | 1 | Select for the retained lower bank |
| mem_cs_hi | output | 1 | Select for the upper bank |
| mem_we | output | 1 | Write strobe for the selected bank |
| mem_idx | output | 12 | Doubleword index within the bank |
| mem_wdata | output | 72 | Data [71:8] and check bits [7:0] to store |
| mem_rdata | input | 72 | Word read, valid the cycle after a select without write |
| err_corr_pulse | output | 1 | Correctable event |
| err_unc_pulse | output | 1 | Uncorrectable event |
| stat_addr | output | 16 | Address of the last event |
| stat_syn | output | 8 | Syndrome of the last event |
| stat_kind | output | 2 | 0 none, 1 corrected, 2 uncorrectable |

## Verification
The decoder is driven with clean words, single flips at every class of position (data bits, individual check bits), double flips mixing data and check bits, and the two stuck patterns. These separate the correction, check-bit-only and uncorrectable paths. Each syndrome is compared against the column learnt from encoding one-hot words, so a wrong column assignment cannot pass. Partial writes use every size with deliberately misaligned offsets over a known byte pattern, which shows that lane choice, alignment masking and untouched bytes are handled independently. They are repeated over correctable and uncorrectable old words to tell a merge of corrected data from a merge of raw data and from an aborted write. Standby is raised both before a request and inside a check cycle, to tell refusal from dropping.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

    localparam int DW = 64;
    localparam int CW = 8;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CHECK = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CORR = 2'd1,
        EV_UNC  = 2'd2
    } ev_kind_e;

    function automatic int popc8(logic [7:0] v);
        int n;
        n = 0;
        for (int b = 0; b < 8; b++) n += int'(v[b]);
        return n;
    endfunction

    // Odd-weight columns: all weight-3 bytes first, then weight-5 until DW filled.
    function automatic logic [DW-1:0][CW-1:0] hsiao_cols();
        logic [DW-1:0][CW-1:0] cols;
        int k;
        cols = '0;
        k = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 1; v < 256; v++) begin
                if (k < DW && popc8(8'(v)) == w) begin
                    cols[k] = 8'(v);
                    k++;
                end
            end
        end
        return cols;
    endfunction

    localparam logic [DW-1:0][CW-1:0] H_COLS = hsiao_cols();

    function automatic logic [DW-1:0] h_row(int j);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = H_COLS[i][j];
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_sram_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] ROW = h_row(j);
        assign chk_o[j] = ^(data_i & ROW);
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_sram_pkg::*;
(
    input  logic [DW+CW-1:0] cw_i,
    output logic [DW-1:0]    data_o,
    output logic [CW-1:0]    syn_o,
    output logic             corr_o,
    output logic             unc_o
);

    logic [DW-1:0] data_raw;
    logic [CW-1:0] chk_calc;
    logic [DW-1:0] hit;
    logic          chk_hit;
    logic          stuck;
    logic          fixable;

    assign data_raw = cw_i[DW+CW-1:CW];

    secded_enc u_enc (
        .data_i (data_raw),
        .chk_o  (chk_calc)
    );

    assign syn_o = chk_calc ^ cw_i[CW-1:0];

    for (genvar i = 0; i < DW; i++) begin : g_col
        assign hit[i] = (syn_o == H_COLS[i]);
    end

    assign chk_hit = $onehot(syn_o);
    assign stuck   = (cw_i == '0) || (&cw_i);
    assign fixable = (|hit) || chk_hit;
    assign corr_o  = !stuck && fixable;
    assign unc_o   = stuck || ((syn_o != '0) && !fixable);
    assign data_o  = stuck ? data_raw : (data_raw ^ hit);

endmodule

// File: rtl/byte_lane_merge.sv
module byte_lane_merge
    import ecc_sram_pkg::*;
(
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] new_i,
    input  logic [1:0]    size_i,
    input  logic [2:0]    off_i,
    output logic [DW-1:0] data_o
);

    localparam int NB = DW / 8;

    logic [2:0] low_mask;
    logic [2:0] group;

    always_comb begin
        unique case (size_i)
            2'd0:    low_mask = 3'd0;
            2'd1:    low_mask = 3'd1;
            2'd2:    low_mask = 3'd3;
            default: low_mask = 3'd7;
        endcase
    end

    assign group = off_i & ~low_mask;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam logic [2:0] LANE = 3'(k);
        logic take;
        assign take = ((LANE & ~low_mask) == group);
        assign data_o[DW-1-8*k -: 8] = take ? new_i[DW-1-8*k -: 8] : old_i[DW-1-8*k -: 8];
    end

endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 mem_cs_lo,
    output logic                 mem_cs_hi,
    output logic                 mem_we,
    output logic [ADDR_W-5:0]    mem_idx,
    output logic [DW+CW-1:0]     mem_wdata,
    input  logic [DW+CW-1:0]     mem_rdata,
    output logic                 err_corr_pulse,
    output logic                 err_unc_pulse,
    output logic [ADDR_W-1:0]    stat_addr,
    output logic [CW-1:0]        stat_syn,
    output logic [1:0]           stat_kind
);

    localparam logic [1:0] SZ_FULL = 2'd3;

    ctrl_state_e st_q, st_d;

    logic              op_write_q;
    logic [1:0]        op_size_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DW-1:0]     op_wdata_q;

    logic              accept;
    logic              full_wr;
    logic              in_check;
    logic              wr_commit;
    logic [ADDR_W-1:0] addr_cur;
    logic [DW-1:0]     wr_data;
    logic [DW-1:0]     merged;
    logic [CW-1:0]     wr_chk;
    logic [DW-1:0]     dec_data;
    logic [CW-1:0]     dec_syn;
    logic              dec_corr;
    logic              dec_unc;

    // ---------------- datapath ----------------
    secded_dec u_dec (
        .cw_i   (mem_rdata),
        .data_o (dec_data),
        .syn_o  (dec_syn),
        .corr_o (dec_corr),
        .unc_o  (dec_unc)
    );

    byte_lane_merge u_merge (
        .old_i  (dec_data),
        .new_i  (op_wdata_q),
        .size_i (op_size_q),
        .off_i  (op_addr_q[2:0]),
        .data_o (merged)
    );

    secded_enc u_enc (
        .data_i (wr_data),
        .chk_o  (wr_chk)
    );

    // ---------------- control ----------------
    assign in_check  = (st_q == ST_CHECK);
    assign req_ready = (st_q == ST_IDLE) && !standby;
    assign accept    = req_valid && req_ready;
    assign full_wr   = accept && req_write && (req_size == SZ_FULL);
    assign wr_commit = in_check && op_write_q && !dec_unc && !standby;

    assign addr_cur  = in_check ? op_addr_q : req_addr;
    assign wr_data   = in_check ? merged : req_wdata;

    assign mem_we    = full_wr || wr_commit;
    assign mem_cs_lo = (accept || wr_commit) && !addr_cur[ADDR_W-1];
    assign mem_cs_hi = (accept || wr_commit) &&  addr_cur[ADDR_W-1];
    assign mem_idx   = addr_cur[ADDR_W-2:3];
    assign mem_wdata = {wr_data, wr_chk};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  st_d = standby ? ST_HOLD : ST_IDLE;
            ST_IDLE: begin
                if (standby)                st_d = ST_HOLD;
                else if (accept && !full_wr) st_d = ST_CHECK;
            end
            ST_CHECK: st_d = standby ? ST_HOLD : ST_IDLE;
            default:  st_d = ST_HOLD;
        endcase
    end

    // outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write_q     <= 1'b0;
            op_size_q      <= '0;
            op_addr_q      <= '0;
            op_wdata_q     <= '0;
            rsp_valid      <= 1'b0;
            rsp_err        <= 1'b0;
            rsp_rdata      <= '0;
            err_corr_pulse <= 1'b0;
            err_unc_pulse  <= 1'b0;
            stat_addr      <= '0;
            stat_syn       <= '0;
            stat_kind      <= EV_NONE;
        end else begin
            rsp_valid      <= 1'b0;
            err_corr_pulse <= 1'b0;
            err_unc_pulse  <= 1'b0;
            if (accept) begin
                op_write_q <= req_write;
                op_size_q  <= req_size;
                op_addr_q  <= req_addr;
                op_wdata_q <= req_wdata;
            end
            if (full_wr) begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b0;
            end
            if (in_check) begin
                rsp_valid      <= 1'b1;
                rsp_rdata      <= dec_data;
                rsp_err        <= dec_unc || (op_write_q && standby);
                err_corr_pulse <= dec_corr;
                err_unc_pulse  <= dec_unc;
                if (dec_corr || dec_unc) begin
                    stat_addr <= op_addr_q;
                    stat_syn  <= dec_syn;
                    stat_kind <= dec_unc ? EV_UNC : EV_CORR;
                end
            end
        end
    end

endmodule

// File: rtl/ecc_sram_ctrl_chk.sv
module ecc_sram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       standby,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [1:0] req_size,
    input logic       mem_we,
    input logic       mem_cs_lo,
    input logic       mem_cs_hi,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       err_corr_pulse,
    input logic       err_unc_pulse
);

    a_r1_full_write_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size == 2'd3)
            |-> (mem_we && $countones({mem_cs_lo, mem_cs_hi}) == 1));

    a_r1_full_write_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size == 2'd3)
            |=> (rsp_valid && !rsp_err));

    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (!rsp_valid ##1 rsp_valid));

    a_r4_corr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr_pulse |=> !err_corr_pulse);

    a_r4_corr_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr_pulse |-> (rsp_valid && !err_unc_pulse));

    a_r10_unc_reports_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_unc_pulse |-> (rsp_valid && rsp_err));

    a_r11_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_cs_lo, mem_cs_hi}));

    a_r12_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!mem_we && !mem_cs_lo && !mem_cs_hi && !req_ready));

endmodule

bind ecc_sram_ctrl ecc_sram_ctrl_chk u_chk (.*);

// File: tb/test_ecc_sram_ctrl.sv
module test_ecc_sram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [63:0] req_wdata = 64'h0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mem_cs_lo, mem_cs_hi, mem_we;
    logic [11:0] mem_idx;
    logic [71:0] mem_wdata;
    logic [71:0] mem_rdata;
    logic        err_corr_pulse, err_unc_pulse;
    logic [15:0] stat_addr;
    logic [7:0]  stat_syn;
    logic [1:0]  stat_kind;

    always #5 clk = ~clk;

    ecc_sram_ctrl i_ecc_sram_ctrl (.*);

    // ---------------- memory model ----------------
    bit   [71:0] mem_lo [int];
    bit   [71:0] mem_hi [int];
    logic [71:0] rd_q = 72'h0;
    int          we_cnt = 0;
    int          rd_cnt = 0;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_cs_lo) begin
            if (mem_we) begin mem_lo[int'(mem_idx)] = mem_wdata; we_cnt++; end
            else begin rd_q <= mem_lo.exists(int'(mem_idx)) ? mem_lo[int'(mem_idx)] : 72'h0; rd_cnt++; end
        end
        if (mem_cs_hi) begin
            if (mem_we) begin mem_hi[int'(mem_idx)] = mem_wdata; we_cnt++; end
            else begin rd_q <= mem_hi.exists(int'(mem_idx)) ? mem_hi[int'(mem_idx)] : 72'h0; rd_cnt++; end
        end
    end

    // ---------------- reference data ----------------
    bit [63:0] ref_mem [int];
    bit [7:0]  col_of [64];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [63:0] ref_merge(bit [63:0] old, bit [63:0] nw, int sz, int off);
        bit [63:0] r;
        int nb, st;
        nb = 1 << sz;
        st = (off / nb) * nb;
        r = old;
        for (int b = 0; b < 8; b++)
            if (b >= st && b < st + nb) r[63-8*b -: 8] = nw[63-8*b -: 8];
        return r;
    endfunction

    function automatic bit [71:0] peek(bit [15:0] a);
        int i;
        i = int'(a[14:3]);
        if (a[15]) return mem_hi.exists(i) ? mem_hi[i] : 72'h0;
        return mem_lo.exists(i) ? mem_lo[i] : 72'h0;
    endfunction

    task automatic poke(bit [15:0] a, bit [71:0] v);
        if (a[15]) mem_hi[int'(a[14:3])] = v;
        else       mem_lo[int'(a[14:3])] = v;
    endtask

    task automatic flip(bit [15:0] a, int pos);
        poke(a, peek(a) ^ (72'h1 << pos));
    endtask

    // per-clock monitor: standby or reset must keep the memory untouched
    always @(negedge clk) begin
        if (standby || !rst_n) chk("R12 no access while held", {69'h0, mem_we, mem_cs_lo, mem_cs_hi}, 72'h0);
    end

    logic        r_err, r_corr, r_unc;
    logic [63:0] r_data;

    task automatic xfer(input bit wr, input bit [1:0] sz, input bit [15:0] a, input bit [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && sz == 2'd3) begin
            chk("R1 full write response next cycle", {71'h0, rsp_valid}, 72'h1);
        end else begin
            chk(wr ? "R8 no response in read cycle" : "R3 no response in read cycle", {71'h0, rsp_valid}, 72'h0);
            @(negedge clk);
            chk(wr ? "R8 response second cycle" : "R3 response second cycle", {71'h0, rsp_valid}, 72'h1);
        end
        r_err = rsp_err; r_data = rsp_rdata; r_corr = err_corr_pulse; r_unc = err_unc_pulse;
        @(negedge clk);
        chk("R4 event pulses last one cycle", {70'h0, err_corr_pulse, err_unc_pulse}, 72'h0);
    endtask

    task automatic wr_full(bit [15:0] a, bit [63:0] d);
        xfer(1'b1, 2'd3, a, d);
        chk("R1 full write no error", {71'h0, r_err}, 72'h0);
        ref_mem[int'(a[15:3])] = d;
    endtask

    task automatic rd_expect(string tag, bit [15:0] a, bit [63:0] d);
        xfer(1'b0, 2'd0, a, 64'h0);
        chk(tag, {r_data, 5'h0, r_err, r_corr, r_unc}, {d, 8'h0});
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int w0, r0, cnt;
        bit [255:0] seen;
        bit [63:0] exp;
        bit [71:0] keep;

        // R13 reset
        repeat (3) @(negedge clk);
        chk("R13 reset outputs", {66'h0, req_ready, rsp_valid, err_corr_pulse, err_unc_pulse, stat_kind}, 72'h0);
        rst_n = 1'b1;
        chk("R13 not ready before first edge", {71'h0, req_ready}, 72'h0);
        @(negedge clk);
        chk("R13 ready one cycle after release", {71'h0, req_ready}, 72'h1);

        // R1 / R11 full writes
        w0 = we_cnt; r0 = rd_cnt;
        wr_full(16'h0000, 64'h0123_4567_89AB_CDEF);
        chk("R1 one write no read", {32'(we_cnt - w0), 32'(rd_cnt - r0), 8'h0}, {32'd1, 32'd0, 8'h0});
        chk("R1 data field stored", {8'h0, peek(16'h0000) >> 8}, {8'h0, 64'h0123_4567_89AB_CDEF});
        chk("R11 lower bank used", {71'h0, bit'(mem_lo.exists(0))}, 72'h1);
        wr_full(16'h8010, 64'hFEDC_BA98_7654_3210);
        chk("R11 upper bank index", {71'h0, bit'(mem_hi.exists(2))}, 72'h1);
        wr_full(16'h0008, 64'h0);
        chk("R2 zero data zero check", {64'h0, peek(16'h0008)}, 136'h0);

        // R2 Hsiao columns
        seen = '0;
        for (int i = 0; i < 64; i++) begin
            wr_full(16'h0010, 64'h1 << i);
            col_of[i] = peek(16'h0010)[7:0];
            cnt = $countones(col_of[i]);
            chk("R2 column weight 3 or 5", {71'h0, bit'(cnt == 3 || cnt == 5)}, 72'h1);
            chk("R2 column distinct", {71'h0, seen[col_of[i]]}, 72'h0);
            seen[col_of[i]] = 1'b1;
        end

        // R3 clean reads
        rd_expect("R3 clean read lower", 16'h0000, 64'h0123_4567_89AB_CDEF);
        rd_expect("R3 clean read upper", 16'h8010, 64'hFEDC_BA98_7654_3210);

        // R4 single data bit
        wr_full(16'h0018, 64'hA5A5_5A5A_C3C3_3C3C);
        flip(16'h0018, 8 + 5);
        xfer(1'b0, 2'd0, 16'h001B, 64'h0);
        chk("R4 corrected data", {r_data, 5'h0, r_err, r_corr, r_unc}, {64'hA5A5_5A5A_C3C3_3C3C, 8'h02});
        chk("R4 status", {38'h0, stat_addr, stat_syn, 8'h0, stat_kind}, {38'h0, 16'h001B, col_of[5], 8'h0, 2'd1});
        flip(16'h0018, 8 + 63);
        flip(16'h0018, 8 + 5);
        xfer(1'b0, 2'd0, 16'h0018, 64'h0);
        chk("R4 corrected msb", {r_data, 5'h0, r_err, r_corr, r_unc}, {64'hA5A5_5A5A_C3C3_3C3C, 8'h02});
        chk("R4 syndrome msb", {64'h0, stat_syn}, {64'h0, col_of[63]});

        // R5 check bit
        wr_full(16'h0020, 64'h1111_2222_3333_4444);
        flip(16'h0020, 3);
        xfer(1'b0, 2'd0, 16'h0020, 64'h0);
        chk("R5 data unchanged", {r_data, 5'h0, r_err, r_corr, r_unc}, {64'h1111_2222_3333_4444, 8'h02});
        chk("R5 syndrome one-hot", {64'h0, stat_syn}, {64'h0, 8'h08});

        // R6 double errors
        wr_full(16'h0028, 64'h0F0F_0F0F_0F0F_0F0F);
        flip(16'h0028, 8 + 1); flip(16'h0028, 8 + 40);
        xfer(1'b0, 2'd0, 16'h0028, 64'h0);
        chk("R6 two data bits", {69'h0, r_err, r_corr, r_unc}, 72'h5);
        chk("R6 kind", {70'h0, stat_kind}, 72'h2);
        flip(16'h0028, 8 + 40); flip(16'h0028, 0);
        xfer(1'b0, 2'd0, 16'h0028, 64'h0);
        chk("R6 data plus check bit", {69'h0, r_err, r_corr, r_unc}, 72'h5);

        // R7 stuck words
        poke(16'h8028, 72'h0);
        xfer(1'b0, 2'd0, 16'h8028, 64'h0);
        chk("R7 all zeros", {69'h0, r_err, r_corr, r_unc}, 72'h5);
        poke(16'h8028, {72{1'b1}});
        xfer(1'b0, 2'd0, 16'h8028, 64'h0);
        chk("R7 all ones", {69'h0, r_err, r_corr, r_unc}, 72'h5);

        // R8 partial writes
        wr_full(16'h0030, 64'h0011_2233_4455_6677);
        xfer(1'b1, 2'd0, 16'h0033, 64'hAAAA_AAAA_AAAA_AAAA);
        exp = ref_merge(64'h0011_2233_4455_6677, 64'hAAAA_AAAA_AAAA_AAAA, 0, 3);
        chk("R8 byte write ok", {69'h0, r_err, r_corr, r_unc}, 72'h0);
        rd_expect("R8 byte lane 3", 16'h0030, exp);
        chk("R8 byte 3 value", {8'h0, exp}, {8'h0, 64'h0011_22AA_4455_6677});
        xfer(1'b1, 2'd1, 16'h0035, 64'h1234_5678_9ABC_DEF0);
        exp = ref_merge(exp, 64'h1234_5678_9ABC_DEF0, 1, 5);
        rd_expect("R8 halfword misaligned offset", 16'h0030, exp);
        xfer(1'b1, 2'd2, 16'h0036, 64'hCAFE_F00D_BEEF_D00D);
        exp = ref_merge(exp, 64'hCAFE_F00D_BEEF_D00D, 2, 6);
        rd_expect("R8 word write upper lanes", 16'h0030, exp);
        chk("R8 final value", {8'h0, exp}, {8'h0, 64'h0011_22AA_BEEF_D00D});

        // R9 merge with corrected old data
        wr_full(16'h0038, 64'h8000_0000_0000_0001);
        flip(16'h0038, 8 + 60);
        xfer(1'b1, 2'd0, 16'h003F, 64'h0000_0000_0000_00EE);
        chk("R9 corr pulse on rmw", {69'h0, r_err, r_corr, r_unc}, 72'h2);
        rd_expect("R9 merged corrected", 16'h0038, 64'h8000_0000_0000_00EE);

        // R10 abort on uncorrectable
        wr_full(16'h0040, 64'h5555_5555_5555_5555);
        flip(16'h0040, 8 + 2); flip(16'h0040, 8 + 9);
        keep = peek(16'h0040);
        w0 = we_cnt;
        xfer(1'b1, 2'd1, 16'h0040, 64'hFFFF_0000_0000_0000);
        chk("R10 error response", {69'h0, r_err, r_corr, r_unc}, 72'h5);
        chk("R10 word unchanged", peek(16'h0040), keep);
        chk("R10 no write", {40'h0, 32'(we_cnt - w0)}, 72'h0);

        // R12 standby refusal
        @(negedge clk);
        standby = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3; req_addr = 16'h0048; req_wdata = 64'h77;
        w0 = we_cnt; r0 = rd_cnt;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R12 not ready in standby", {71'h0, req_ready}, 72'h0);
        end
        req_valid = 1'b0;
        standby = 1'b0;
        chk("R12 still held at release", {71'h0, req_ready}, 72'h0);
        @(negedge clk);
        chk("R12 ready after release", {71'h0, req_ready}, 72'h1);
        chk("R12 nothing accessed", {8'h0, 32'(we_cnt - w0), 32'(rd_cnt - r0)}, 72'h0);

        // R12 standby inside check cycle
        keep = peek(16'h0030);
        w0 = we_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 16'h0030; req_wdata = 64'hFF00_0000_0000_0000;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        standby = 1'b1;
        @(negedge clk);
        chk("R12 blocked write responds error", {70'h0, rsp_valid, rsp_err}, 72'h3);
        standby = 1'b0;
        chk("R12 blocked write not stored", peek(16'h0030), keep);
        chk("R12 blocked write no strobe", {40'h0, 32'(we_cnt - w0)}, 72'h0);
        @(negedge clk);
        rd_expect("R12 contents kept", 16'h0030, 64'h0011_22AA_BEEF_D00D);

        finish_run();
    end

endmodule